// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel samples. The stream arrives on three wires: a bit clock, a frame line that also selects the channel, and a data line. All three are brought into a single fast system clock and oversampled. Rising edges of the bit clock are found in that domain, and one shift register collects data bits for every framing convention. Once both words of a frame are complete, the block presents a left and a right 24-bit two's-complement sample together with a one-cycle valid strobe.

Four framing conventions are supported, and four word lengths. Words are always sent most significant bit first. Two options adjust the interface. The first inverts the bit clock before edge detection, so data can be taken on the opposite physical edge. The second delays the frame line by one bit clock before framing is decoded. The system clock must run at least four times faster than the bit clock. The configuration inputs are expected to stay static while the stream runs.

Top module: `audio_rx`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and both sample outputs are 0.
- R2: `fmt_i` selects the framing: 00 = I2S, 01 = DSP early, 10 = right-justified, 11 = DSP late. `res_i` selects the word length: 00 = 24, 01 = 20, 10 = 18, 11 = 16 bits. Each word is placed in the top bits of its 24-bit output, and the bits below it are zero.
- R3: I2S: a frame-line low selects left and a high selects right. On each change of the frame line, the word's MSB is taken on the second rising bit-clock edge that samples the new level.
- R4: Right-justified: a frame-line high selects left and a low selects right. The last bit before a frame-line change is the LSB of the word that just ended.
- R5: DSP early: the left MSB is taken on the first rising bit-clock edge that samples the frame line high. The right word follows on the very next bit.
- R6: DSP late: the left MSB is taken one bit-clock edge after the DSP early position. The right word follows on the very next bit.
- R7: In both DSP modes, any frame pulse width from 1 to 8 bit clocks gives the same samples.
- R8: When `sck_inv_i` is 1, data and frame are sampled on the falling physical edge of `sck_i`.
- R9: When `ws_dly_i` is 1, the frame line is delayed by one bit clock before decoding. A stream whose frame line leads by one bit then decodes exactly as the undelayed stream does.
- R10: `valid_o` pulses for exactly one cycle when a right word completes after a left word has completed since the previous pulse. A right word with no prior left word produces no pulse. Between pulses, both sample outputs hold their values.
- R11: A word whose last bit arrives on the same bit-clock edge as the frame event for the next word is still captured correctly, and the next word still starts at its normal position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Frame / channel-select line (asynchronous) |
| sd_i | input | 1 | Serial data line (asynchronous) |
| fmt_i | input | 2 | Framing select (see R2) |
| res_i | input | 2 | Word length select (see R2) |
| sck_inv_i | input | 1 | Invert the bit clock before edge detection |
| ws_dly_i | input | 1 | Delay the frame line by one bit clock |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
Two functions can fall on the same bit-clock edge. One is the capture of a word's final bit. The other is detection of the frame event that schedules the next word. Two tight streams provoke this: an I2S stream whose channel slot is exactly the word length, and a DSP late stream whose frame is exactly two words long. In both, the LSB arrives on the edge where the frame line moves. Each is judged by requiring every expected sample pair to appear, bit-exact, with no pair lost and no extra one.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'b00,
    FMT_DSP_E = 2'b01,
    FMT_RJ    = 2'b10,
    FMT_DSP_L = 2'b11
  } fmt_e;

  function automatic logic [4:0] word_len(input logic [1:0] res);
    case (res)
      2'b00:   return 5'd24;
      2'b01:   return 5'd20;
      2'b10:   return 5'd18;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  input  logic sck_inv_i,
  output logic edge_o,
  output logic ws_o,
  output logic sd_o
);
  localparam int unsigned NSIG = 3;

  logic [STAGES-1:0][NSIG-1:0] pipe_q;
  logic sck_s, sck_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= {sd_i, ws_i, sck_i};
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sck_s = pipe_q[STAGES-1][0] ^ sck_inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= sck_inv_i;
    else         sck_q <= sck_s;
  end

  // data and frame leave the same stage as the clock, so they line up with the strobe
  assign edge_o = sck_s & ~sck_q;
  assign ws_o   = pipe_q[STAGES-1][1];
  assign sd_o   = pipe_q[STAGES-1][2];
endmodule

// File: rtl/audio_rx_frame.sv
module audio_rx_frame
  import audio_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic ws_i,
  input  logic ws_dly_i,
  input  fmt_e fmt_i,
  output logic start_o,
  output logic start_chan_o,
  output logic rj_end_o,
  output logic rj_chan_o,
  output logic chain_o
);
  logic ws_raw_q, ws_p_q, chg_q, rise_q;
  logic ws_e, chg, rise;

  assign ws_e = ws_dly_i ? ws_raw_q : ws_i;
  assign chg  = ws_e ^ ws_p_q;
  assign rise = ws_e & ~ws_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_raw_q <= 1'b0;
      ws_p_q   <= 1'b0;
      chg_q    <= 1'b0;
      rise_q   <= 1'b0;
    end else if (edge_i) begin
      ws_raw_q <= ws_i;
      ws_p_q   <= ws_e;
      chg_q    <= chg;
      rise_q   <= rise;
    end
  end

  always_comb begin
    unique case (fmt_i)
      FMT_I2S:   start_o = edge_i & chg_q;
      FMT_DSP_E: start_o = edge_i & rise;
      FMT_DSP_L: start_o = edge_i & rise_q;
      default:   start_o = 1'b0;
    endcase
  end

  // channel: 0 = left, 1 = right
  assign start_chan_o = (fmt_i == FMT_I2S) & ws_e;
  assign rj_end_o     = edge_i & (fmt_i == FMT_RJ) & chg;
  assign rj_chan_o    = ~ws_p_q;
  assign chain_o      = (fmt_i == FMT_DSP_E) | (fmt_i == FMT_DSP_L);
endmodule

// File: rtl/audio_rx_shift.sv
module audio_rx_shift #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CNT_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                edge_i,
  input  logic                sd_i,
  input  logic                start_i,
  input  logic                start_chan_i,
  input  logic                rj_end_i,
  input  logic                rj_chan_i,
  input  logic                chain_i,
  input  logic [CNT_W-1:0]    wlen_i,
  output logic                cap_o,
  output logic                cap_chan_o,
  output logic [SAMPLE_W-1:0] cap_word_o
);
  logic [SAMPLE_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]    cnt_q, bitno;
  logic                run_q, chan_q, word_end;

  assign sh_n  = {sh_q[SAMPLE_W-2:0], sd_i};
  assign bitno = start_i ? CNT_W'(1) : (run_q ? CNT_W'(cnt_q + 1'b1) : '0);
  assign word_end = edge_i & (start_i | run_q) & (bitno == wlen_i);

  assign cap_o      = word_end | rj_end_i;
  assign cap_chan_o = rj_end_i ? rj_chan_i : (start_i ? start_chan_i : chan_q);
  // right-justified ends before the current bit; MSB-first modes end on it
  assign cap_word_o = (rj_end_i ? sh_q : sh_n) << (SAMPLE_W - int'(wlen_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      chan_q <= 1'b0;
    end else if (edge_i) begin
      sh_q <= sh_n;
      if (start_i) begin
        run_q  <= 1'b1;
        cnt_q  <= CNT_W'(1);
        chan_q <= start_chan_i;
      end else if (run_q) begin
        if (bitno == wlen_i) begin
          if (chain_i && !chan_q) begin
            chan_q <= 1'b1;
            cnt_q  <= '0;
          end else begin
            run_q <= 1'b0;
          end
        end else begin
          cnt_q <= bitno;
        end
      end
    end
  end
endmodule

// File: rtl/audio_rx.sv
module audio_rx
  import audio_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          res_i,
  input  logic                sck_inv_i,
  input  logic                ws_dly_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);

  logic sck_edge, ws_s, sd_s;
  logic start, start_chan, rj_end, rj_chan, chain;
  logic cap, cap_chan;
  logic [SAMPLE_W-1:0] cap_word, left_hold_q;
  logic left_ok_q;
  logic [CNT_W-1:0] wlen;

  assign wlen = CNT_W'(word_len(res_i));

  audio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .ws_i, .sd_i, .sck_inv_i,
    .edge_o(sck_edge), .ws_o(ws_s), .sd_o(sd_s)
  );

  audio_rx_frame u_frame (
    .clk_i, .rst_ni, .edge_i(sck_edge), .ws_i(ws_s), .ws_dly_i,
    .fmt_i(fmt_e'(fmt_i)), .start_o(start), .start_chan_o(start_chan),
    .rj_end_o(rj_end), .rj_chan_o(rj_chan), .chain_o(chain)
  );

  audio_rx_shift #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni, .edge_i(sck_edge), .sd_i(sd_s),
    .start_i(start), .start_chan_i(start_chan),
    .rj_end_i(rj_end), .rj_chan_i(rj_chan), .chain_i(chain),
    .wlen_i(wlen), .cap_o(cap), .cap_chan_o(cap_chan), .cap_word_o(cap_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      left_ok_q   <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap) begin
        if (!cap_chan) begin
          left_hold_q <= cap_word;
          left_ok_q   <= 1'b1;
        end else if (left_ok_q) begin
          left_o    <= left_hold_q;
          right_o   <= cap_word;
          valid_o   <= 1'b1;
          left_ok_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          res_i,
  input logic                sck_edge,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o
);
  logic [SAMPLE_W-1:0] low_mask;

  always_comb begin
    case (res_i)
      2'b00:   low_mask = '0;
      2'b01:   low_mask = SAMPLE_W'(24'h00000F);
      2'b10:   low_mask = SAMPLE_W'(24'h00003F);
      default: low_mask = SAMPLE_W'(24'h0000FF);
    endcase
  end

  assert_single_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_between_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_valid_after_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sck_edge));

  assert_zero_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (((left_o & low_mask) == '0) && ((right_o & low_mask) == '0)));
endmodule

bind audio_rx audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .res_i(res_i), .sck_edge(sck_edge),
  .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
);

// File: tb/audio_rx_tb.sv
module audio_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int MAXB       = 512;
  localparam int NFR        = 3;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic [1:0]  fmt_i = 2'b00, res_i = 2'b00;
  logic        sck_inv_i = 1'b0, ws_dly_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, fails = 0;
  int nv = 0;
  logic [23:0] got_l [8];
  logic [23:0] got_r [8];
  logic        prev_v = 1'b0;
  logic [23:0] prev_l = '0, prev_r = '0;
  int          wide_err = 0, hold_err = 0;

  logic sd_a [MAXB];
  logic ws_a [MAXB];

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_rx u_dut (
    .clk_i(clk), .rst_ni, .sck_i, .ws_i, .sd_i, .fmt_i, .res_i,
    .sck_inv_i, .ws_dly_i, .left_o, .right_o, .valid_o
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o && nv < 8) begin
        got_l[nv] = left_o;
        got_r[nv] = right_o;
      end
      if (valid_o) nv++;
      if (valid_o && prev_v) wide_err++;
      if (!valid_o && (left_o !== prev_l || right_o !== prev_r)) hold_err++;
    end
    prev_v = valid_o;
    prev_l = left_o;
    prev_r = right_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic place(input int start, input int n, input logic [23:0] w);
    for (int b = 0; b < n; b++) sd_a[start + b] = w[n-1-b];
  endtask

  // fmt codes: 0 I2S, 1 DSP early, 2 right-justified, 3 DSP late
  task automatic run_case(input string tag, input logic [1:0] fmt, input logic [1:0] res,
                          input bit inv, input bit dly, input int slot, input int pw,
                          input logic [23:0] seed);
    int n, pre, len, s;
    logic [23:0] wl [NFR];
    logic [23:0] wr [NFR];
    logic [23:0] el, er;
    bit idle_ws, post_ws;
    n   = (res == 2'b00) ? 24 : (res == 2'b01) ? 20 : (res == 2'b10) ? 18 : 16;
    pre = 4;
    len = pre + NFR * 2 * slot + slot + 8;
    idle_ws = (fmt == 2'b00);
    post_ws = (fmt == 2'b10);
    for (int i = 0; i < MAXB; i++) begin
      sd_a[i] = 1'b0;
      ws_a[i] = (i < pre) ? idle_ws : post_ws;
    end
    for (int f = 0; f < NFR; f++) begin
      wl[f] = seed ^ (24'h3C5A96 * (f + 1));
      wr[f] = ~seed ^ (24'h81E7 * (f + 3));
      s = pre + f * 2 * slot;
      for (int i = 0; i < 2 * slot; i++) begin
        case (fmt)
          2'b00: ws_a[s+i] = (i >= slot);
          2'b10: ws_a[s+i] = (i < slot);
          default: ws_a[s+i] = (i < pw);
        endcase
      end
      case (fmt)
        2'b00: begin place(s + 1, n, wl[f]); place(s + slot + 1, n, wr[f]); end
        2'b10: begin place(s + slot - n, n, wl[f]); place(s + 2*slot - n, n, wr[f]); end
        2'b01: begin place(s, n, wl[f]); place(s + n, n, wr[f]); end
        default: begin place(s + 1, n, wl[f]); place(s + 1 + n, n, wr[f]); end
      endcase
    end

    rst_ni = 1'b0;
    fmt_i = fmt; res_i = res; sck_inv_i = inv; ws_dly_i = dly;
    sck_i = inv; sd_i = 1'b0; ws_i = ws_a[0];
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    nv = 0;
    for (int i = 0; i < len; i++) begin
      ws_i = dly ? ((i + 1 < len) ? ws_a[i+1] : ws_a[i]) : ws_a[i];
      sd_i = sd_a[i];
      repeat (HALF) @(negedge clk);
      sck_i = ~inv;
      repeat (HALF) @(negedge clk);
      sck_i = inv;
    end
    repeat (10) @(negedge clk);

    chk(nv == NFR, tag, "pair count (R10)", 48'(nv), 48'(NFR));
    for (int f = 0; f < NFR && f < nv; f++) begin
      el = wl[f] << (24 - n);
      er = wr[f] << (24 - n);
      chk(got_l[f] === el && got_r[f] === er, tag, $sformatf("frame %0d samples", f),
          {got_l[f], got_r[f]}, {el, er});
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0 && left_o === '0 && right_o === '0, "R1", "reset outputs",
        {23'd0, valid_o, left_o}, 48'd0);
  endtask

  task automatic t_i2s24;        run_case("R3 R2 i2s 24", 2'b00, 2'b00, 0, 0, 32, 0, 24'hA53C91); endtask
  task automatic t_i2s16_tight;  run_case("R11 R3 i2s 16 tight", 2'b00, 2'b11, 0, 0, 16, 0, 24'h17F0C3); endtask
  task automatic t_rj20;         run_case("R4 R2 rj 20", 2'b10, 2'b01, 0, 0, 32, 0, 24'hC0FFEE); endtask
  task automatic t_rj18;         run_case("R4 R2 rj 18", 2'b10, 2'b10, 0, 0, 24, 0, 24'h5A5A13); endtask
  task automatic t_dsp_early;    run_case("R5 R7 dsp early pw1", 2'b01, 2'b00, 0, 0, 32, 1, 24'h9E3779); endtask
  task automatic t_dsp_late;     run_case("R6 R7 dsp late pw8", 2'b11, 2'b11, 0, 0, 32, 8, 24'hB4E21D); endtask
  task automatic t_dsp_late_tight; run_case("R11 R6 dsp late tight", 2'b11, 2'b00, 0, 0, 24, 3, 24'h6D2B79); endtask
  task automatic t_sck_inv;      run_case("R8 i2s inverted clock", 2'b00, 2'b10, 1, 0, 32, 0, 24'hF00D42); endtask
  task automatic t_ws_dly;       run_case("R9 dsp early delayed frame", 2'b01, 2'b01, 0, 1, 32, 2, 24'h2468AC); endtask
  task automatic t_inv_dly;      run_case("R8 R9 rj both options", 2'b10, 2'b00, 1, 1, 32, 0, 24'hE1D2C3); endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s24();
    t_i2s16_tight();
    t_rj20();
    t_rj18();
    t_dsp_early();
    t_dsp_late();
    t_dsp_late_tight();
    t_sck_inv();
    t_ws_dly();
    t_inv_dly();
    chk(wide_err == 0, "R10", "valid wider than one cycle", 48'(wide_err), 48'd0);
    chk(hold_err == 0, "R10", "outputs moved without valid", 48'(hold_err), 48'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule